// File: doc/BRIEF.md
# Resistive Cell Forming-State Tamper Sequencer

This block decides whether a bank of resistive memory cells has already been formed (burned in) before the chip's first use. A cell that has never been formed behaves like a fixed resistor, and its read value cannot be changed by a normal-level write. A cell that has been formed switches like any memory bit. At manufacture nothing should be formed yet, so a bank that switches points to tampering.

On a start pulse the sequencer runs four transactions in a fixed order. It writes a known pattern at the normal switching level and reads the bank back into a first holding register. It then writes the bitwise complement of that pattern at the same level and reads the bank into a second holding register. One cycle later it XORs the two holding registers. If any bit of the result is set, it raises the tamper flag, and it pulses done. The burn-in drive level is never requested. The analog drivers, the sense amplifiers and the cells themselves are outside this block.

Writes and reads each use a valid/ready handshake. The block raises valid and holds it, together with the write data and the level code, until the array side returns ready. The array side may hold ready low for any number of cycles, and the sequence simply stalls in that step. The two channels are never valid at the same time.

Top module: `tamper_seq`

## Requirements
- R1: When `start` is high while the block is idle, the next cycle raises `wr_valid` with `wr_data` equal to the parameter `PAT_A` and `wr_level` = 2'b01 (normal switching drive). These stay until the cycle after the `wr_ready` handshake.
- R2: After the first write handshake, the next cycle raises `rd_valid`. The `rd_data` value present at the read handshake is kept as the first read-back word.
- R3: After the first read handshake, the next cycle raises `wr_valid` with `wr_data` equal to the bitwise complement of `PAT_A` and `wr_level` = 2'b01. These are held until the `wr_ready` handshake.
- R4: After the second write handshake, the next cycle raises `rd_valid`. The `rd_data` value at that handshake is kept as the second read-back word.
- R5: `done` is high for exactly one cycle, two cycles after the second read handshake. In that same cycle `tamper` becomes the OR of all bits of the XOR of the two read-back words. With fixed (unformed) cells this gives 0, and with any formed cell it gives 1.
- R6: `tamper` keeps its value from the `done` cycle through every idle cycle, and is cleared to 0 in the cycle after the next accepted start.
- R7: A `start` pulse while `busy` is high is ignored: the running sequence continues unchanged and produces a single `done`.
- R8: `form_en` stays 0, and `wr_level` never carries the burn-in code 2'b10. When no write is requested, `wr_level` is 2'b00.
- R9: Once `wr_valid` or `rd_valid` is high it stays high until its ready is seen, and write data and level stay stable meanwhile. `wr_valid` and `rd_valid` are never high together.
- R10: A synchronous reset (`rst` high at a clock edge) returns the block to idle with `busy`, `done`, `tamper`, `wr_valid` and `rd_valid` low, even in the middle of a sequence.
- R11: `busy` is high from the cycle after an accepted start up to and including the compare cycle, and is low in the `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a check when idle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-check pulse |
| tamper | output | 1 | Cells switched; valid from done until next start |
| wr_valid | output | 1 | Write request to the array |
| wr_ready | input | 1 | Array accepts the write |
| wr_data | output | W | Word to write |
| wr_level | output | 2 | Drive level: 00 none, 01 switching, 10 burn-in |
| rd_valid | output | 1 | Read request to the array |
| rd_ready | input | 1 | Array returns read data |
| rd_data | input | W | Read-back word, sampled at the read handshake |
| form_en | output | 1 | Burn-in enable, kept inactive |

## Verification
The bench models the cell bank as a mix of formed bits, which follow writes, and unformed bits, which return a fixed value. It covers all-unformed, all-formed and single-formed-bit banks. A compare that used the wrong register or skipped the complement write would flag an untouched bank or miss a single switching bit. Ready is stalled for several cycles, so a sequencer that moved on without the handshake, or let its data change while waiting, would drift from the clock-by-clock model. A start pulse in mid-run, and a reset in mid-run, target designs that restart, pulse done twice, or keep a stale tamper flag.

// File: rtl/tamper_seq_pkg.sv
package tamper_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_A,
    ST_RD_A,
    ST_WR_B,
    ST_RD_B,
    ST_CMP
  } seq_state_t;

  localparam logic [1:0] LVL_OFF    = 2'b00;
  localparam logic [1:0] LVL_SWITCH = 2'b01;
  localparam logic [1:0] LVL_FORM   = 2'b10;

endpackage

// File: rtl/tamper_seq_fsm.sv
module tamper_seq_fsm
  import tamper_seq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic wr_ready,
  input  logic rd_ready,
  output logic wr_valid,
  output logic wr_second,
  output logic rd_valid,
  output logic cap_first,
  output logic cap_second,
  output logic cmp_go,
  output logic start_acc,
  output logic busy
);

  seq_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start)    state_d = ST_WR_A;
      ST_WR_A: if (wr_ready) state_d = ST_RD_A;
      ST_RD_A: if (rd_ready) state_d = ST_WR_B;
      ST_WR_B: if (wr_ready) state_d = ST_RD_B;
      ST_RD_B: if (rd_ready) state_d = ST_CMP;
      ST_CMP:                state_d = ST_IDLE;
      default:               state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  assign wr_valid   = (state_q == ST_WR_A) || (state_q == ST_WR_B);
  assign wr_second  = (state_q == ST_WR_B);
  assign rd_valid   = (state_q == ST_RD_A) || (state_q == ST_RD_B);
  assign cap_first  = (state_q == ST_RD_A) && rd_ready;
  assign cap_second = (state_q == ST_RD_B) && rd_ready;
  assign cmp_go     = (state_q == ST_CMP);
  assign start_acc  = (state_q == ST_IDLE) && start;
  assign busy       = (state_q != ST_IDLE);

endmodule

// File: rtl/tamper_capture.sv
module tamper_capture #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap_first,
  input  logic         cap_second,
  input  logic [W-1:0] rd_data,
  output logic [W-1:0] word_first,
  output logic [W-1:0] word_second
);

  always_ff @(posedge clk) begin
    if (rst) begin
      word_first  <= '0;
      word_second <= '0;
    end else begin
      if (cap_first)  word_first  <= rd_data;
      if (cap_second) word_second <= rd_data;
    end
  end

endmodule

// File: rtl/tamper_compare.sv
module tamper_compare #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_acc,
  input  logic         cmp_go,
  input  logic [W-1:0] word_a,
  input  logic [W-1:0] word_b,
  output logic         tamper,
  output logic         done
);

  logic [W-1:0] diff;

  for (genvar g = 0; g < W; g++) begin : g_bit
    assign diff[g] = word_a[g] ^ word_b[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tamper <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= cmp_go;
      if (start_acc)   tamper <= 1'b0;
      else if (cmp_go) tamper <= |diff;
    end
  end

endmodule

// File: rtl/tamper_seq.sv
module tamper_seq
  import tamper_seq_pkg::*;
#(
  parameter int           W     = 8,
  parameter logic [W-1:0] PAT_A = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  output logic         busy,
  output logic         done,
  output logic         tamper,
  output logic         wr_valid,
  input  logic         wr_ready,
  output logic [W-1:0] wr_data,
  output logic [1:0]   wr_level,
  output logic         rd_valid,
  input  logic         rd_ready,
  input  logic [W-1:0] rd_data,
  output logic         form_en
);

  logic         wr_second, cap_first, cap_second, cmp_go, start_acc;
  logic [W-1:0] word_first, word_second;

  tamper_seq_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .wr_ready   (wr_ready),
    .rd_ready   (rd_ready),
    .wr_valid   (wr_valid),
    .wr_second  (wr_second),
    .rd_valid   (rd_valid),
    .cap_first  (cap_first),
    .cap_second (cap_second),
    .cmp_go     (cmp_go),
    .start_acc  (start_acc),
    .busy       (busy)
  );

  tamper_capture #(.W(W)) u_cap (
    .clk         (clk),
    .rst         (rst),
    .cap_first   (cap_first),
    .cap_second  (cap_second),
    .rd_data     (rd_data),
    .word_first  (word_first),
    .word_second (word_second)
  );

  tamper_compare #(.W(W)) u_cmp (
    .clk       (clk),
    .rst       (rst),
    .start_acc (start_acc),
    .cmp_go    (cmp_go),
    .word_a    (word_first),
    .word_b    (word_second),
    .tamper    (tamper),
    .done      (done)
  );

  assign wr_data  = wr_second ? ~PAT_A : PAT_A;
  assign wr_level = wr_valid ? LVL_SWITCH : LVL_OFF;
  assign form_en  = (wr_level == LVL_FORM);

endmodule

// File: rtl/tamper_seq_chk.sv
module tamper_seq_chk
  import tamper_seq_pkg::*;
#(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic         tamper,
  input logic         wr_valid,
  input logic         wr_ready,
  input logic [W-1:0] wr_data,
  input logic [1:0]   wr_level,
  input logic         rd_valid,
  input logic         rd_ready,
  input logic         form_en
);

  assert_no_forming_R8: assert property (@(posedge clk) disable iff (rst)
    busy |-> (!form_en && (wr_level != LVL_FORM)));

  assert_wr_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data) && $stable(wr_level)));

  assert_rd_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> rd_valid);

  assert_one_channel_R9: assert property (@(posedge clk) disable iff (rst)
    !(wr_valid && rd_valid));

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_idle_R11: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_start_only_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  assert_tamper_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(tamper));

endmodule

bind tamper_seq tamper_seq_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .tamper   (tamper),
  .wr_valid (wr_valid),
  .wr_ready (wr_ready),
  .wr_data  (wr_data),
  .wr_level (wr_level),
  .rd_valid (rd_valid),
  .rd_ready (rd_ready),
  .form_en  (form_en)
);

// File: tb/tb_tamper_seq.sv
module tb_tamper_seq;
  localparam int W = 8;
  localparam logic [W-1:0] A = 8'hC3;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, rdy = 1'b0;
  logic busy, done, tamper, wr_valid, wr_ready, rd_valid, rd_ready, form_en;
  logic [W-1:0] wr_data, rd_data;
  logic [1:0] wr_level;

  always #5 clk = ~clk;

  tamper_seq #(.W(W), .PAT_A(A)) dut (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .tamper(tamper), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .wr_level(wr_level), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data), .form_en(form_en)
  );

  int checks = 0, failures = 0, dn = 0, cyc = 0, lat = 0, cnt = 0;
  logic [W-1:0] formed = '0, fixed = '0, mem = '0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // cell bank: formed bits follow writes, unformed bits return a fixed value
  assign rd_data  = (mem & formed) | (fixed & ~formed);
  assign wr_ready = rdy;
  assign rd_ready = rdy;
  always @(posedge clk) if (wr_valid && wr_ready) mem <= wr_data;

  always @(negedge clk) begin
    if (!(wr_valid || rd_valid) || rdy) cnt = 0;
    if (wr_valid || rd_valid) begin
      rdy = (cnt >= lat);
      cnt++;
    end else rdy = 1'b0;
  end

  // behavioural reference model
  int ph = 0;
  logic m_tam = 0, m_done = 0, m_ok = 0;
  logic [W-1:0] r0 = '0, r1 = '0;
  always @(posedge clk) begin
    if (rst) begin
      ph = 0; m_tam = 0; m_done = 0; m_ok = 1; r0 = '0; r1 = '0;
    end else begin
      m_done = 0;
      case (ph)
        0: if (start) begin ph = 1; m_tam = 0; end
        1: if (wr_ready) ph = 2;
        2: if (rd_ready) begin r0 = rd_data; ph = 3; end
        3: if (wr_ready) ph = 4;
        4: if (rd_ready) begin r1 = rd_data; ph = 5; end
        default: begin m_tam = |(r0 ^ r1); m_done = 1; ph = 0; end
      endcase
    end
  end

  always @(negedge clk) begin
    if (done) dn++;
    if (m_ok && !rst) begin
      logic ewv, erv;
      logic [W-1:0] ewd;
      ewv = (ph == 1) || (ph == 3);
      erv = (ph == 2) || (ph == 4);
      ewd = (ph == 3) ? ~A : A;
      chk(busy == (ph != 0), "R11 busy", 32'(busy), 32'(ph != 0));
      chk(done == m_done, "R5 done", 32'(done), 32'(m_done));
      chk(tamper == m_tam, "R6 tamper", 32'(tamper), 32'(m_tam));
      chk(wr_valid == ewv, "R1 R3 wr_valid", 32'(wr_valid), 32'(ewv));
      chk(rd_valid == erv, "R2 R4 rd_valid", 32'(rd_valid), 32'(erv));
      if (ewv) chk(wr_data == ewd, "R1 R3 wr_data", 32'(wr_data), 32'(ewd));
      chk(wr_level == (ewv ? 2'b01 : 2'b00), "R8 wr_level", 32'(wr_level),
          32'(ewv ? 2'b01 : 2'b00));
      chk(form_en == 1'b0, "R8 form_en", 32'(form_en), 32'h0);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL R5 watchdog expired actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic run(input logic [W-1:0] f, input logic [W-1:0] x, input int l,
                     input bit poke, input bit exp_t);
    int d0, n;
    formed = f; fixed = x; lat = l;
    d0 = dn;
    start = 1'b1; step(1); start = 1'b0;
    chk(tamper == 1'b0, "R6 cleared after start", 32'(tamper), 32'h0);
    chk(busy == 1'b1, "R11 busy after start", 32'(busy), 32'h1);
    if (poke) begin
      step(2); start = 1'b1; step(1); start = 1'b0;
    end
    n = 0;
    while (!done && n < 500) begin step(1); n++; end
    chk(done == 1'b1, "R5 done reached", 32'(done), 32'h1);
    chk(tamper == exp_t, "R5 tamper result", 32'(tamper), 32'(exp_t));
    step(4);
    chk(busy == 1'b0, "R7 no restart", 32'(busy), 32'h0);
    chk(dn - d0 == 1, "R7 single done pulse", 32'(dn - d0), 32'h1);
    chk(tamper == exp_t, "R6 tamper held", 32'(tamper), 32'(exp_t));
  endtask

  initial begin
    step(3);
    chk(busy == 1'b0, "R10 reset busy", 32'(busy), 32'h0);
    chk(done == 1'b0, "R10 reset done", 32'(done), 32'h0);
    chk(tamper == 1'b0, "R10 reset tamper", 32'(tamper), 32'h0);
    chk(wr_valid == 1'b0 && rd_valid == 1'b0, "R10 reset requests",
        32'({wr_valid, rd_valid}), 32'h0);
    rst = 1'b0;
    step(2);

    run(8'h00, 8'h5A, 0, 0, 1'b0);
    run(8'hFF, 8'h00, 0, 0, 1'b1);
    run(8'h10, 8'h00, 2, 0, 1'b1);
    run(8'h00, 8'hFF, 3, 1, 1'b0);
    run(8'h81, 8'h7E, 1, 1, 1'b1);

    // reset in the middle of a run, after a tamper result of 1
    formed = 8'hFF; lat = 2;
    start = 1'b1; step(1); start = 1'b0;
    step(3);
    rst = 1'b1; step(1);
    chk(busy == 1'b0, "R10 mid-run reset busy", 32'(busy), 32'h0);
    chk(wr_valid == 1'b0 && rd_valid == 1'b0, "R10 mid-run reset requests",
        32'({wr_valid, rd_valid}), 32'h0);
    chk(tamper == 1'b0, "R10 mid-run reset tamper", 32'(tamper), 32'h0);
    rst = 1'b0; step(2);

    run(8'hF0, 8'h00, 0, 0, 1'b1);
    run(8'h00, 8'h3C, 4, 0, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule